// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM built from four 8-bit lanes. The lanes share one address bus and one active-low output enable. Each lane has its own active-low chip select and active-low write enable. The host raises a request with an address, write data, a direction bit and lane enables. The sequencer then runs one read cycle or one write cycle in which the write enable controls the end of the write, and it answers with a single-cycle acknowledge.

The external part has minimum times in nanoseconds. The sequencer turns each of them into a whole number of clock cycles, using the clock period given as a parameter, and no phase is shorter than one cycle. A build-time parameter sets the host word to 32, 16 or 8 bits. In the narrow widths, the low host address bits choose a lane pair or a single lane. Write data is copied onto every lane, and read data is right-justified and zero-extended. The data bus is split into an output word, an input word and one drive enable, so it can be joined to a tri-state pad at the chip edge.

Top module: `sram_lane_seq`

## Requirements
- R1: During and after reset, all chip selects, all write enables and the output enable are high (inactive). The drive enable and the acknowledge are low.
- R2: A read drives low the chip selects of the chosen lanes and the output enable, with every write enable high, for RD = ceil(max(70,70,35) ns / period) cycles (7 at 10 ns). Read data is captured on the last of those cycles and is valid while the acknowledge is high.
- R3: A write holds the chosen lanes' write enables and chip selects low for WP = ceil(60 ns / period) cycles (6 at 10 ns). The output enable stays high for the whole write, and every lane whose write enable is low also has its chip select low.
- R4: After the pulse, a hold phase of max(ceil(5 ns / period), ceil(70 ns / period) − WP) cycles keeps the address and data driven (1 at 10 ns). From the cycle in which the request is set up to the cycle that shows the acknowledge, an isolated read takes RD+1 clock cycles and an isolated write takes WP+hold+1.
- R5: In 32-bit mode, host lane enable bit i selects lane i, which carries data bits [8i+7:8i]. A lane that is not enabled keeps its chip select high and its stored byte unchanged.
- R6: After the output enable rises, the drive enable stays low for at least TA = ceil(25 ns / period) cycles (3 at 10 ns). When a write follows a read back to back, the gap is exactly TA.
- R7: The acknowledge is high for exactly one cycle per request. A request is accepted only when the sequencer is idle and the acknowledge is low.
- R8: In 16-bit mode, host address bit 0 selects the lane pair (1 = lanes 3 and 2) and host address bits [19:1] form the memory address. Host lane enable bits [1:0] gate the two lanes of the pair. The low 16 bits of write data go to both pairs, and read data is the selected pair, zero-extended.
- R9: In 8-bit mode, host address bits [1:0] select a single lane and bits [20:2] form the memory address. Lane enable bit 0 gates that lane. The low write byte goes to all lanes, and read data is the selected byte, zero-extended. At most one chip select is low.
- R10: The drive enable is high only from the start of a write pulse through its hold phase, and it is low in the cycle that shows the acknowledge.
- R11: The memory address does not change while any chip select is low, and it stays put for at least one cycle after a write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+2 | Host address (low bits pick the lane group in narrow modes) |
| req_wdata | input | DATA_W | Host write data |
| req_be | input | LANES | Host lane enables |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Aligned read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | LANES | Per-lane chip selects, active low |
| mem_we_n | output | LANES | Per-lane write enables, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The bench attacks the read-to-write turnaround by issuing a write the instant a read is acknowledged. A sequencer with a short turnaround count would drive the bus while the memory model is still in its high-impedance tail, which shows up as contention or as a gap smaller than three cycles. The memory model returns filler bytes until the full access time has passed and rejects write pulses shorter than six cycles, so any phase length that is off by one shows up as wrong data or a model violation. Partial lane enables and both narrow modes are exercised. A misrouted lane select or a missing replication or justification step would corrupt the neighbouring bytes or return the wrong lane.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_t;

  // whole cycles covering a minimum time, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             final_cyc,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign final_cyc = (cnt == CNT_W'(1));
  assign expired   = (cnt <= CNT_W'(1));
endmodule

// File: rtl/sram_lane_route.sv
module sram_lane_route #(
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int ACCESS_W = 32,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic [1:0]        sel,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] wdata_rep
);
  localparam int LPW    = ACCESS_W / LANE_W;
  localparam int GROUPS = LANES / LPW;

  int grp;

  always_comb begin
    grp = int'(sel) % GROUPS;
    for (int i = 0; i < LANES; i++)
      lane_mask[i] = ((i / LPW) == grp) && be[i % LPW];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rep
    assign wdata_rep[g*LANE_W +: LANE_W] = wdata[(g % LPW)*LANE_W +: LANE_W];
  end

  always_comb begin
    p_group_width_r9: assert ($countones(lane_mask) <= LPW)
      else $error("lane mask wider than one access group");
  end
endmodule

// File: rtl/sram_read_align.sv
module sram_read_align #(
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int ACCESS_W = 32,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] aligned
);
  localparam int GROUPS = LANES / (ACCESS_W / LANE_W);

  int grp;

  always_comb begin
    grp     = int'(sel) % GROUPS;
    aligned = '0;
    for (int j = 0; j < ACCESS_W; j++)
      aligned[j] = bus_in[grp*ACCESS_W + j];
  end
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 19,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int ACCESS_W = 32,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 50,
  parameter int T_CW_NS  = 60,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_AH_NS  = 5,
  parameter int T_HZ_NS  = 25,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W+1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int EXB     = (ACCESS_W == 32) ? 0 : (ACCESS_W == 16) ? 1 : 2;
  localparam int RD_CYC  = ns_to_cyc(imax(T_RC_NS, imax(T_AA_NS, T_OE_NS)), CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS)), CLK_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int AH_CYC  = ns_to_cyc(T_AH_NS, CLK_NS);
  localparam int WH_CYC  = imax(AH_CYC, WC_CYC - WP_CYC);
  localparam int TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(WH_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t state;
  logic [LANES-1:0]  lane_mask, mask_q;
  logic [DATA_W-1:0] wdata_rep, rd_aligned;
  logic [1:0]        sel_q;
  logic              accept, ph_load, ph_last, tz_clear, ph_unused, tz_last_unused;
  logic [CNT_W-1:0]  ph_val;

  sram_lane_route #(.LANES(LANES), .LANE_W(LANE_W), .ACCESS_W(ACCESS_W)) u_route (
    .sel(req_addr[1:0]), .be(req_be), .wdata(req_wdata),
    .lane_mask(lane_mask), .wdata_rep(wdata_rep));

  sram_read_align #(.LANES(LANES), .LANE_W(LANE_W), .ACCESS_W(ACCESS_W)) u_align (
    .sel(sel_q), .bus_in(mem_dq_in), .aligned(rd_aligned));

  sram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
    .final_cyc(ph_last), .expired(ph_unused));

  sram_phase_timer #(.CNT_W(CNT_W)) u_turn (
    .clk(clk), .rst(rst), .load(state == ST_READ && ph_last),
    .load_val(CNT_W'(TA_CYC)), .final_cyc(tz_last_unused), .expired(tz_clear));

  assign accept = (state == ST_IDLE) && req && !ack;

  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    if (accept && !req_we) begin
      ph_load = 1'b1;  ph_val = CNT_W'(RD_CYC);
    end else if ((accept && req_we && tz_clear) || (state == ST_TURN && tz_clear)) begin
      ph_load = 1'b1;  ph_val = CNT_W'(WP_CYC);
    end else if (state == ST_WPULSE && ph_last) begin
      ph_load = 1'b1;  ph_val = CNT_W'(WH_CYC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_cs_n   <= '1;
      mem_we_n   <= '1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_dq_out <= '0;
      mem_addr   <= '0;
      ack        <= 1'b0;
      rsp_rdata  <= '0;
      mask_q     <= '0;
      sel_q      <= '0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          mem_addr   <= req_addr[EXB +: ADDR_W];
          mask_q     <= lane_mask;
          sel_q      <= req_addr[1:0];
          mem_dq_out <= wdata_rep;
          if (!req_we) begin
            mem_cs_n <= ~lane_mask;
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end else if (tz_clear) begin
            mem_cs_n  <= ~lane_mask;
            mem_we_n  <= ~lane_mask;
            mem_dq_oe <= 1'b1;
            state     <= ST_WPULSE;
          end else begin
            state <= ST_TURN;
          end
        end
        ST_TURN: if (tz_clear) begin
          mem_cs_n  <= ~mask_q;
          mem_we_n  <= ~mask_q;
          mem_dq_oe <= 1'b1;
          state     <= ST_WPULSE;
        end
        ST_READ: if (ph_last) begin
          rsp_rdata <= rd_aligned;
          mem_cs_n  <= '1;
          mem_oe_n  <= 1'b1;
          ack       <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_WPULSE: if (ph_last) begin
          mem_we_n <= '1;
          mem_cs_n <= '1;
          state    <= ST_WHOLD;
        end
        ST_WHOLD: if (ph_last) begin
          mem_dq_oe <= 1'b0;
          ack       <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent watch on cycles elapsed since the output enable went high
  logic [CNT_W-1:0] oe_high_cnt;
  always_ff @(posedge clk) begin
    if (rst)                              oe_high_cnt <= CNT_W'(TA_CYC);
    else if (!mem_oe_n)                   oe_high_cnt <= '0;
    else if (oe_high_cnt < CNT_W'(TA_CYC)) oe_high_cnt <= oe_high_cnt + 1'b1;
  end

  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_high_cnt >= CNT_W'(TA_CYC)))
    else $error("data driven inside the memory's release window");

  p_no_oe_in_write_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we_n != '1) |-> mem_oe_n)
    else $error("output enable low during a write pulse");

  p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
    ((~mem_we_n) & mem_cs_n) == '0)
    else $error("write enable low on an unselected lane");

  p_drive_only_write_r10: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && state inside {ST_WPULSE, ST_WHOLD}))
    else $error("bus driven outside a write");

  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack)
    else $error("acknowledge longer than one cycle");

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
    ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr))
    else $error("address moved during a selected access");

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WHOLD) |-> $stable(mem_addr))
    else $error("address moved during write hold");

  if (ACCESS_W == 8) begin : g_byte_chk
    p_one_lane_r9: assert property (@(posedge clk) disable iff (rst)
      $countones(~mem_cs_n) <= 1)
      else $error("more than one lane selected in byte mode");
  end
endmodule

// File: tb/tb_sram_lane_seq.sv
module tb_sram_model #(
  parameter int RD_E = 7,
  parameter int WP_E = 6,
  parameter int TA_E = 3
) (
  input  logic        clk,
  input  logic [18:0] addr,
  input  logic [3:0]  cs_n,
  input  logic [3:0]  we_n,
  input  logic        oe_n,
  input  logic [31:0] dq_wr,
  input  logic        dq_oe,
  output logic [31:0] dq_rd,
  output int          viol
);
  logic [7:0]  mem [4][64];
  logic [7:0]  wbyte [4];
  int          wcnt [4];
  int          age, tail;
  logic        oe_q, anycs_q, driving;
  logic [3:0]  we_q;
  logic [18:0] addr_q;

  initial begin
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 64; k++) mem[i][k] = 8'h00;
      wcnt[i] = 0; wbyte[i] = 8'h00;
    end
    viol = 0; age = 0; tail = 0; oe_q = 1'b1; anycs_q = 1'b0;
    we_q = 4'hf; addr_q = '0; dq_rd = 32'h5A5A5A5A;
  end

  always @(negedge clk) begin
    if (cs_n != 4'hf && anycs_q && addr != addr_q) viol++;
    if (!oe_n && cs_n != 4'hf && we_n == 4'hf) age = (addr == addr_q) ? age + 1 : 1;
    else age = 0;
    driving = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!cs_n[i] && !oe_n && we_n[i]) begin
        driving = 1'b1;
        dq_rd[i*8 +: 8] = (age >= RD_E) ? mem[i][addr[5:0]] : 8'hA5;
      end else begin
        dq_rd[i*8 +: 8] = 8'h5A;
      end
    end
    if (oe_n && !oe_q) tail = TA_E;
    if (dq_oe && (driving || tail > 0)) viol++;
    if (tail > 0) tail--;
    for (int i = 0; i < 4; i++) begin
      if (!we_n[i]) begin
        if (cs_n[i] || !dq_oe) viol++;
        wcnt[i]++;
        wbyte[i] = dq_wr[i*8 +: 8];
      end else if (!we_q[i]) begin
        if (wcnt[i] < WP_E || addr != addr_q) viol++;
        else mem[i][addr[5:0]] = wbyte[i];
        wcnt[i] = 0;
      end
    end
    oe_q = oe_n; we_q = we_n; addr_q = addr; anycs_q = (cs_n != 4'hf);
  end
endmodule

module tb_sram_lane_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RD_E = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP_E = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WH_E = 1;
  localparam int TA_E = (25 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  int cur = 0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic        ack_k [3];
  logic [31:0] rdata_k [3];
  logic [18:0] addr_k [3];
  logic [3:0]  cs_k [3];
  logic [3:0]  we_k [3];
  logic        oe_k [3];
  logic [31:0] dqo_k [3];
  logic        dqoe_k [3];
  logic [31:0] dqi_k [3];
  int          viol_k [3];
  logic        req_k [3];

  always_comb for (int k = 0; k < 3; k++) req_k[k] = req && (cur == k);

  sram_lane_seq #(.ACCESS_W(32)) dut (
    .clk(clk), .rst(rst), .req(req_k[0]), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack_k[0]), .rsp_rdata(rdata_k[0]),
    .mem_addr(addr_k[0]), .mem_cs_n(cs_k[0]), .mem_we_n(we_k[0]), .mem_oe_n(oe_k[0]),
    .mem_dq_out(dqo_k[0]), .mem_dq_oe(dqoe_k[0]), .mem_dq_in(dqi_k[0]));
  sram_lane_seq #(.ACCESS_W(16)) dut16 (
    .clk(clk), .rst(rst), .req(req_k[1]), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack_k[1]), .rsp_rdata(rdata_k[1]),
    .mem_addr(addr_k[1]), .mem_cs_n(cs_k[1]), .mem_we_n(we_k[1]), .mem_oe_n(oe_k[1]),
    .mem_dq_out(dqo_k[1]), .mem_dq_oe(dqoe_k[1]), .mem_dq_in(dqi_k[1]));
  sram_lane_seq #(.ACCESS_W(8)) dut8 (
    .clk(clk), .rst(rst), .req(req_k[2]), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack_k[2]), .rsp_rdata(rdata_k[2]),
    .mem_addr(addr_k[2]), .mem_cs_n(cs_k[2]), .mem_we_n(we_k[2]), .mem_oe_n(oe_k[2]),
    .mem_dq_out(dqo_k[2]), .mem_dq_oe(dqoe_k[2]), .mem_dq_in(dqi_k[2]));

  for (genvar k = 0; k < 3; k++) begin : g_mem
    tb_sram_model #(.RD_E(RD_E), .WP_E(WP_E), .TA_E(TA_E)) u_mem (
      .clk(clk), .addr(addr_k[k]), .cs_n(cs_k[k]), .we_n(we_k[k]), .oe_n(oe_k[k]),
      .dq_wr(dqo_k[k]), .dq_oe(dqoe_k[k]), .dq_rd(dqi_k[k]), .viol(viol_k[k]));
  end

  logic o_ack, o_oe, o_dqoe;
  logic [31:0] o_rdata, o_dqo;
  logic [3:0]  o_cs, o_we;
  always_comb begin
    o_ack = ack_k[cur]; o_oe = oe_k[cur]; o_dqoe = dqoe_k[cur];
    o_rdata = rdata_k[cur]; o_dqo = dqo_k[cur]; o_cs = cs_k[cur]; o_we = we_k[cur];
  end

  // port monitors
  int gap = 0, last_gap = -1, ack_double = 0;
  logic dqoe_q = 1'b0, ack_q = 1'b0;
  always @(negedge clk) begin
    if (!o_oe) gap = 0;
    else if (!o_dqoe) gap++;
    if (o_dqoe && !dqoe_q) last_gap = gap;
    if (o_ack && ack_q) ack_double++;
    dqoe_q = o_dqoe; ack_q = o_ack;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [20:0] a, input logic [31:0] d,
                       input logic [3:0] b, output logic [31:0] rd, output int lat,
                       output int wlow, output int olow, output logic [3:0] lanes,
                       output logic [31:0] dqv, output int oe_in_wr);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = b;
    lat = 0; wlow = 0; olow = 0; lanes = '0; dqv = '0; oe_in_wr = 0;
    do begin
      @(negedge clk);
      lat++;
      if (o_we != 4'hf) begin
        wlow++; lanes |= ~o_we; dqv = o_dqo;
        if (!o_oe) oe_in_wr++;
      end
      if (!o_oe) begin olow++; lanes |= ~o_cs; end
    end while (!o_ack && lat < 300);
    rd = o_rdata;
    req = 1'b0;
    check(o_ack, "R7 ack seen", {31'd0, o_ack}, 32'd1);
    check(!o_dqoe && o_cs == 4'hf && o_we == 4'hf, "R10 bus released at ack",
          {o_dqoe, 23'd0, o_cs, o_we}, {1'b0, 23'd0, 8'hff});
  endtask

  task automatic t_reset();
    cur = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(o_cs == 4'hf && o_we == 4'hf && o_oe && !o_dqoe && !o_ack, "R1 reset state",
          {o_cs, o_we, 21'd0, o_oe, o_dqoe, o_ack}, {8'hff, 21'd0, 3'b100});
    rst = 1'b0;
    @(negedge clk);
    check(o_cs == 4'hf && o_we == 4'hf && o_oe && !o_dqoe, "R1 idle after reset",
          {o_cs, o_we, 22'd0, o_oe, o_dqoe}, {8'hff, 22'd0, 2'b10});
  endtask

  task automatic t_full32();
    logic [31:0] rd, dqv; logic [3:0] ln; int lat, wl, ol, oew;
    cur = 0;
    do_op(1'b1, 21'h10, 32'h11223344, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    check(wl == WP_E, "R3 write pulse length", wl, WP_E);
    check(lat == WP_E + WH_E + 1, "R4 write latency", lat, WP_E + WH_E + 1);
    check(ln == 4'hf && dqv == 32'h11223344, "R5 full word lanes", {ln, dqv[27:0]}, {4'hf, 28'h1223344});
    check(oew == 0, "R3 output enable high in write", oew, 0);
    do_op(1'b0, 21'h10, 32'h0, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    check(ol == RD_E, "R2 read strobe length", ol, RD_E);
    check(lat == RD_E + 1, "R4 read latency", lat, RD_E + 1);
    check(rd == 32'h11223344, "R2 read data", rd, 32'h11223344);
  endtask

  task automatic t_lanes32();
    logic [31:0] rd, dqv; logic [3:0] ln; int lat, wl, ol, oew;
    cur = 0;
    do_op(1'b1, 21'h10, 32'hAABBCCDD, 4'b0101, rd, lat, wl, ol, ln, dqv, oew);
    check(ln == 4'b0101, "R5 partial lane selects", ln, 4'b0101);
    do_op(1'b0, 21'h10, 32'h0, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    check(rd == 32'h11BB33DD, "R5 unselected lanes kept", rd, 32'h11BB33DD);
  endtask

  task automatic t_turn32();
    logic [31:0] rd, dqv; logic [3:0] ln; int lat, wl, ol, oew;
    cur = 0;
    do_op(1'b0, 21'h10, 32'h0, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    do_op(1'b1, 21'h11, 32'h01020304, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    check(last_gap == TA_E, "R6 read-to-write turnaround", last_gap, TA_E);
    check(oew == 0, "R3 no output enable in turnaround write", oew, 0);
    do_op(1'b0, 21'h11, 32'h0, 4'hf, rd, lat, wl, ol, ln, dqv, oew);
    check(rd == 32'h01020304, "R6 write after turnaround stored", rd, 32'h01020304);
  endtask

  task automatic t_mode16();
    logic [31:0] rd, dqv; logic [3:0] ln; int lat, wl, ol, oew;
    cur = 1;
    do_op(1'b1, 21'h0B, 32'h0000BEEF, 4'b0011, rd, lat, wl, ol, ln, dqv, oew);
    check(ln == 4'b1100 && dqv == 32'hBEEFBEEF, "R8 upper pair write",
          {ln, dqv[27:0]}, {4'b1100, 28'hEEFBEEF});
    do_op(1'b1, 21'h0A, 32'hFFFF1234, 4'b0011, rd, lat, wl, ol, ln, dqv, oew);
    check(ln == 4'b0011, "R8 lower pair write", ln, 4'b0011);
    do_op(1'b0, 21'h0B, 32'h0, 4'b0011, rd, lat, wl, ol, ln, dqv, oew);
    check(rd == 32'h0000BEEF, "R8 upper pair read justified", rd, 32'h0000BEEF);
    do_op(1'b0, 21'h0A, 32'h0, 4'b0011, rd, lat, wl, ol, ln, dqv, oew);
    check(rd == 32'h00001234, "R8 lower pair read", rd, 32'h00001234);
  endtask

  task automatic t_mode8();
    logic [31:0] rd, dqv; logic [3:0] ln; int lat, wl, ol, oew;
    cur = 2;
    for (int k = 0; k < 4; k++) begin
      do_op(1'b1, 21'(28 + k), 32'(8'h40 + k), 4'b0001, rd, lat, wl, ol, ln, dqv, oew);
      check(ln == 4'(1 << k) && dqv == {4{8'(8'h40 + k)}}, "R9 byte lane write",
            {ln, dqv[27:0]}, {4'(1 << k), 28'(dqv[27:0])});
    end
    for (int k = 0; k < 4; k++) begin
      do_op(1'b0, 21'(28 + k), 32'h0, 4'b0001, rd, lat, wl, ol, ln, dqv, oew);
      check(rd == 32'(8'h40 + k), "R9 byte read justified", rd, 32'(8'h40 + k));
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full32();
    t_lanes32();
    t_turn32();
    t_mode16();
    t_mode8();
    repeat (5) @(negedge clk);
    check(ack_double == 0, "R7 ack single cycle", ack_double, 0);
    for (int k = 0; k < 3; k++)
      check(viol_k[k] == 0, "R11 memory timing and address hold", viol_k[k], 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule